// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block performs rectangle operations on a linear, byte-addressed frame buffer. The frame buffer holds pixels of `bypp` bytes each, and rows are `pitch` bytes apart. Both values come from the colour depth and the screen width given at start. A fill paints one colour over a w×h region. It builds the first row by cycling through the colour bytes, then produces every later row by reading that first row back. A copy moves a w×h region from a source origin to a destination origin. It stays correct when the regions overlap, because it chooses the row order and the byte order within a row from the relative position of the two origins.

The engine drives a single-port byte memory. Reads have one cycle of latency. A one-cycle `start` strobe launches an operation. `busy` stays high while the operation runs. When the last byte has been written, `done` pulses for one cycle, and the destination rectangle is presented on the dirty outputs so that a downstream redraw queue can record it.

Top module: `rect_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: The bytes per pixel are bypp = (depth + 7) >> 3 and the row pitch is bypp × scr_w. Pixel (x, y) starts at byte address x·bypp + y·pitch, and only the bytes of the destination rectangle are written.
- R3: A fill writes the colour bytes in order from least significant to most significant. Byte k of a pixel gets colour[8k+7:8k]. Row 0 is written directly, with no memory reads.
- R4: Every fill row after the first ends up byte-identical to the first row. Those rows are produced by reading the first row back.
- R5: A copy of non-overlapping regions leaves the destination equal to the source as it was before the copy. It makes exactly w·h·bypp writes.
- R6: When dst_y > src_y, the copy runs bottom-up. Its first read is in source row src_y + h − 1, and an overlapping copy gives the same result as a copy through a temporary buffer.
- R7: When dst_y ≤ src_y, the copy runs top-down. Its first read is in source row src_y, and an overlapping copy gives the same result as a copy through a temporary buffer.
- R8: When dst_x > src_x, the copy moves each row from its last byte to its first, so its first read is at byte w·bypp − 1 of its starting row. Otherwise each row runs first byte to last. A same-row overlapping shift in either direction is correct.
- R9: `busy` is high from the cycle after an accepted start through the last write. `done` is a single-cycle pulse in the cycle after the last write, with `busy` already low. No write occurs while `busy` is low.
- R10: While `done` is high, `dirty_x`, `dirty_y`, `dirty_w` and `dirty_h` equal the destination x, y, w and h of the operation that finished.
- R11: A `start` that arrives while `busy` is high is ignored. It produces no extra `done`, no extra writes, and no change to the dirty outputs.
- R12: A start with w = 0 or h = 0 performs no reads and no writes. `done` still pulses once, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle operation launch |
| op_copy | input | 1 | 1 = copy, 0 = fill |
| depth | input | 6 | Colour depth in bits (1 to 32) |
| scr_w | input | XW | Screen width in pixels |
| src_x | input | XW | Copy source x |
| src_y | input | XW | Copy source y |
| dst_x | input | XW | Destination x |
| dst_y | input | XW | Destination y |
| rect_w | input | XW | Rectangle width in pixels |
| rect_h | input | XW | Rectangle height in rows |
| colour | input | 32 | Fill colour, least significant byte first |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read byte address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write byte address |
| mem_wr_data | output | 8 | Memory write byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dirty_x | output | XW | Dirty rectangle x |
| dirty_y | output | XW | Dirty rectangle y |
| dirty_w | output | XW | Dirty rectangle width |
| dirty_h | output | XW | Dirty rectangle height |

## Verification
A fill spends one cycle on each byte of its first row and two cycles (read, then write) on every other byte. A copy spends two cycles on every byte. `done` and the dirty rectangle therefore appear one cycle after the final write edge, and a zero-sized operation answers one cycle after its start. The latency depends on size, so the scoreboard does not wait a fixed number of cycles. The monitor samples on the falling edge and compares each `done` against the queued expectation: write count, first read address and dirty rectangle. The driver compares the whole memory with its own model once `done` has been seen.

// File: rtl/rect_engine.sv
module rect_engine #(
  parameter int XW = 12,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_copy,
  input  logic [5:0]    depth,
  input  logic [XW-1:0] scr_w,
  input  logic [XW-1:0] src_x,
  input  logic [XW-1:0] src_y,
  input  logic [XW-1:0] dst_x,
  input  logic [XW-1:0] dst_y,
  input  logic [XW-1:0] rect_w,
  input  logic [XW-1:0] rect_h,
  input  logic [31:0]   colour,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [7:0]    mem_wr_data,
  output logic          busy,
  output logic          done,
  output logic [XW-1:0] dirty_x,
  output logic [XW-1:0] dirty_y,
  output logic [XW-1:0] dirty_w,
  output logic [XW-1:0] dirty_h
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WRB} st_t;
  st_t st;

  logic          op_q, up_q, rev_q;
  logic [2:0]    bypp_q;
  logic [AW-1:0] pitch_q, rowlen_q;
  logic [XW-1:0] sx_q, sy_q, dx_q, dy_q, w_q, h_q;
  logic [31:0]   colour_q;
  logic [XW-1:0] r;
  logic [AW-1:0] c;
  logic [1:0]    ph;

  logic [2:0]    bypp_in;
  logic [XW-1:0] ry;
  logic [AW-1:0] cb, src_addr, dst_addr;
  logic          need_rd, last_byte, last_row;

  assign bypp_in = 3'(({1'b0, depth} + 7'd7) >> 3);

  assign ry = up_q  ? h_q - XW'(1) - r       : r;
  assign cb = rev_q ? rowlen_q - AW'(1) - c  : c;

  assign dst_addr = (AW'(dy_q) + AW'(ry)) * pitch_q + AW'(dx_q) * AW'(bypp_q) + cb;
  assign src_addr = op_q ? (AW'(sy_q) + AW'(ry)) * pitch_q + AW'(sx_q) * AW'(bypp_q) + cb
                         : AW'(dy_q) * pitch_q + AW'(dx_q) * AW'(bypp_q) + cb;

  assign need_rd     = op_q || (r != '0);
  assign mem_rd_en   = (st == S_RUN) && need_rd;
  assign mem_rd_addr = src_addr;
  assign mem_wr_en   = ((st == S_RUN) && !need_rd) || (st == S_WRB);
  assign mem_wr_addr = dst_addr;
  assign mem_wr_data = (st == S_WRB) ? mem_rd_data : colour_q[{ph, 3'b000} +: 8];

  assign last_byte = (c == rowlen_q - AW'(1));
  assign last_row  = (r == h_q - XW'(1));

  assign dirty_x = dx_q;
  assign dirty_y = dy_q;
  assign dirty_w = w_q;
  assign dirty_h = h_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      op_q     <= 1'b0;
      up_q     <= 1'b0;
      rev_q    <= 1'b0;
      bypp_q   <= 3'd1;
      pitch_q  <= '0;
      rowlen_q <= '0;
      sx_q     <= '0;
      sy_q     <= '0;
      dx_q     <= '0;
      dy_q     <= '0;
      w_q      <= '0;
      h_q      <= '0;
      colour_q <= '0;
      r        <= '0;
      c        <= '0;
      ph       <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q     <= op_copy;
          up_q     <= op_copy && (dst_y > src_y);
          rev_q    <= op_copy && (dst_x > src_x);
          bypp_q   <= bypp_in;
          pitch_q  <= AW'(scr_w) * AW'(bypp_in);
          rowlen_q <= AW'(rect_w) * AW'(bypp_in);
          sx_q     <= src_x;
          sy_q     <= src_y;
          dx_q     <= dst_x;
          dy_q     <= dst_y;
          w_q      <= rect_w;
          h_q      <= rect_h;
          colour_q <= colour;
          r        <= '0;
          c        <= '0;
          ph       <= '0;
          if (rect_w == '0 || rect_h == '0) done <= 1'b1;
          else begin
            busy <= 1'b1;
            st   <= S_RUN;
          end
        end
        S_RUN:   if (need_rd) st <= S_WRB;
        S_WRB:   st <= S_RUN;
        default: st <= S_IDLE;
      endcase
      if (mem_wr_en) begin
        if (last_byte) begin
          c  <= '0;
          ph <= '0;
          if (last_row) begin
            st   <= S_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end else r <= r + XW'(1);
        end else begin
          c  <= c + AW'(1);
          ph <= ({1'b0, ph} == bypp_q - 3'd1) ? 2'd0 : ph + 2'd1;
        end
      end
    end
  end

  AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_wr_en |-> busy); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |=> mem_wr_en); // R5
  AST_DIRTY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(dirty_x) && $stable(dirty_y) && $stable(dirty_w) && $stable(dirty_h)))); // R10
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(dirty_x) && $stable(dirty_y) && $stable(dirty_w) && $stable(dirty_h))); // R11

endmodule

// File: tb/tb_rect_engine.sv
module tb_rect_engine;
  localparam int XW = 12;
  localparam int AW = 20;
  localparam int MSZ = 4096;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0, op_copy = 0;
  logic [5:0] depth = 6'd24;
  logic [XW-1:0] scr_w = '0, src_x = '0, src_y = '0, dst_x = '0, dst_y = '0, rect_w = '0, rect_h = '0;
  logic [31:0] colour = '0;
  logic mem_rd_en, mem_wr_en, busy, done;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [7:0] mem_rd_data, mem_wr_data;
  logic [XW-1:0] dirty_x, dirty_y, dirty_w, dirty_h;

  always #10 clk = ~clk;

  rect_engine #(.XW(XW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_copy(op_copy), .depth(depth),
    .scr_w(scr_w), .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
    .rect_w(rect_w), .rect_h(rect_h), .colour(colour),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .busy(busy), .done(done), .dirty_x(dirty_x), .dirty_y(dirty_y),
    .dirty_w(dirty_w), .dirty_h(dirty_h));

  logic [7:0] mem [0:MSZ-1];
  logic [7:0] exp_mem [0:MSZ-1];
  logic [7:0] tmp [0:MSZ-1];

  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_wr_addr[11:0]] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:0]];
  end

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  typedef struct {
    int x, y, w, h, nwr, rd0;
    bit chk_rd;
    string tag;
  } item_t;
  item_t q[$];

  int wrcnt = 0, rdcnt = 0, rd0 = -1;
  bit seen_rd = 0, prev_done = 0;

  always @(negedge clk) if (rst_n) begin
    if (mem_wr_en) wrcnt++;
    if (mem_rd_en) begin
      rdcnt++;
      if (!seen_rd) begin seen_rd = 1; rd0 = int'(mem_rd_addr); end
    end
    if (prev_done && done) chk(0, "R9", "done longer than one cycle", 1, 0);
    if (done) begin
      if (q.size() == 0) chk(0, "R11", "unexpected done", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(!busy, "R9", {it.tag, " busy at done"}, busy, 0);
        chk(dirty_x == XW'(it.x) && dirty_y == XW'(it.y) && dirty_w == XW'(it.w) && dirty_h == XW'(it.h),
            "R10", {it.tag, " dirty rect x,y"}, dirty_x * 10000 + dirty_y, it.x * 10000 + it.y);
        chk(wrcnt == it.nwr, "R5", {it.tag, " write count"}, wrcnt, it.nwr);
        if (it.nwr == 0) chk(rdcnt == 0, "R12", {it.tag, " reads on empty op"}, rdcnt, 0);
        if (it.chk_rd) chk(rd0 == it.rd0, "R6", {it.tag, " first read address (R6/R7/R8 ordering)"}, rd0, it.rd0);
      end
      wrcnt = 0; rdcnt = 0; seen_rd = 0; rd0 = -1;
    end
    prev_done = done;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "R9", "watchdog expired", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_op(input bit cp, input int dep, input int sw, input int sx, input int sy,
                        input int dx, input int dy, input int w, input int h,
                        input logic [31:0] col, input bit inject, input string tag);
    int bp, pitch, rl, n;
    item_t it;
    bit ok;
    int bad;
    bp = (dep + 7) >> 3;
    pitch = bp * sw;
    rl = w * bp;
    if (cp) begin
      for (int r = 0; r < h; r++)
        for (int k = 0; k < rl; k++) tmp[r * rl + k] = exp_mem[(sy + r) * pitch + sx * bp + k];
      for (int r = 0; r < h; r++)
        for (int k = 0; k < rl; k++) exp_mem[(dy + r) * pitch + dx * bp + k] = tmp[r * rl + k];
    end else begin
      for (int r = 0; r < h; r++)
        for (int k = 0; k < rl; k++) exp_mem[(dy + r) * pitch + dx * bp + k] = col[8 * (k % bp) +: 8];
    end
    it.x = dx; it.y = dy; it.w = w; it.h = h; it.nwr = w * h * bp; it.tag = tag;
    it.chk_rd = cp && (w > 0) && (h > 0);
    it.rd0 = (sy + ((dy > sy) ? h - 1 : 0)) * pitch + sx * bp + ((dx > sx) ? rl - 1 : 0);
    q.push_back(it);
    @(negedge clk);
    op_copy = cp; depth = 6'(dep); scr_w = XW'(sw); src_x = XW'(sx); src_y = XW'(sy);
    dst_x = XW'(dx); dst_y = XW'(dy); rect_w = XW'(w); rect_h = XW'(h); colour = col; start = 1;
    @(negedge clk);
    start = 0;
    if (inject) begin
      repeat (4) @(negedge clk);
      chk(busy == 1, "R9", {tag, " busy mid-operation"}, busy, 1);
      op_copy = 1; src_x = 0; src_y = 0; dst_x = 9; dst_y = 1; rect_w = 3; rect_h = 2; start = 1;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, "R9", {tag, " done not seen"}, n, 0);
    @(negedge clk);
    ok = 1; bad = -1;
    for (int a = 0; a < MSZ; a++) if (ok && mem[a] !== exp_mem[a]) begin ok = 0; bad = a; end
    if (ok) chk(1, "R2", {tag, " memory image"}, 0, 0);
    else chk(0, cp ? "R5" : "R3", {tag, " memory byte mismatch"}, mem[bad], exp_mem[bad]);
  endtask

  initial begin
    for (int a = 0; a < MSZ; a++) begin
      mem[a] = 8'((a * 7 + 3) & 255);
      exp_mem[a] = 8'((a * 7 + 3) & 255);
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd_en && !mem_wr_en, "R1", "reset state",
        {busy, done, mem_rd_en, mem_wr_en}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done, "R1", "idle after reset", {busy, done}, 0);

    run_op(0, 24, 32, 0, 0, 2, 3, 5, 4, 32'h00A1B2C3, 0, "R3 R4 fill bypp3");
    run_op(0, 16, 40, 0, 0, 1, 10, 6, 3, 32'h00001234, 0, "R4 fill bypp2");
    run_op(0, 8, 32, 0, 0, 7, 20, 9, 2, 32'h0000005A, 0, "R2 fill bypp1");
    run_op(0, 32, 20, 0, 0, 3, 30, 4, 3, 32'hDEADBEEF, 0, "R2 fill bypp4");
    run_op(1, 24, 32, 0, 0, 10, 12, 4, 3, 0, 0, "R5 copy disjoint");
    run_op(1, 24, 32, 4, 2, 4, 4, 5, 6, 0, 0, "R6 copy bottom-up overlap");
    run_op(1, 24, 32, 6, 8, 6, 5, 5, 6, 0, 0, "R7 copy top-down overlap");
    run_op(1, 16, 32, 2, 14, 4, 14, 8, 2, 0, 0, "R8 copy row shift right");
    run_op(1, 16, 32, 6, 16, 3, 16, 8, 2, 0, 0, "R8 copy row shift left");
    run_op(1, 24, 32, 3, 20, 5, 22, 6, 4, 0, 0, "R6 R8 copy diagonal overlap");
    run_op(1, 8, 32, 20, 25, 18, 25, 10, 3, 0, 0, "R7 copy bypp1 shift left");
    run_op(0, 24, 32, 0, 0, 4, 4, 0, 3, 32'h00FFFFFF, 0, "R12 zero width");
    run_op(1, 24, 32, 1, 1, 4, 4, 3, 0, 0, 0, "R12 zero height");
    run_op(0, 24, 32, 0, 0, 0, 26, 6, 3, 32'h00112233, 1, "R11 start while busy");

    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R11", "pending expectations", q.size(), 0);
    chk(!busy && !done, "R11", "idle at end", {busy, done}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule